// File: doc/BRIEF.md
# Pulse-Swallow Frequency Synthesizer Core with Lock Qualifier

This block holds the digital part of an integer-N frequency synthesizer. One divider turns oscillator events into a reference strobe. A pulse-swallow divider turns VCO-side events into a feedback strobe. It models a 32/33 dual-modulus prescaler and steers that prescaler's modulus with a swallow count. A three-state phase/frequency detector compares the two strobes and drives UP and DOWN pulses toward an external charge pump.

A lock qualifier measures the phase error of each comparison. When it sees enough consecutive in-window comparisons, it drops the charge-pump current to low. A divider reprogramming strobe forces the current back to high at once. With the qualifier disabled, a software bit chooses the current directly.

The block runs entirely on one system clock. Oscillator and VCO activity arrive as single-cycle event enables, so the phase error is counted in system-clock cycles.

Top module: `pll_synth_core`

## Requirements
- R1: The reference strobe fires once every `ref_div`+1 cycles that have `osc_tick` high. With `ref_div` >= 1 the strobe never lasts two cycles.
- R2: The feedback strobe fires once every 32·`main_cnt` + `swal_cnt` + 32 cycles that have `vco_tick` high. Within one feedback cycle, the prescaler counts `swal_cnt` periods of 33 events followed by `main_cnt`+1−`swal_cnt` periods of 32 events.
- R3: The boundary settings `swal_cnt` = 0 and `swal_cnt` = `main_cnt` (up to 31) give the division that R2 states. Settings with `swal_cnt` > `main_cnt` are outside the supported range.
- R4: `up` goes high the cycle after a reference strobe and `dn` goes high the cycle after a feedback strobe. In the cycle after both are high, both return low. The leading input's output is high alone for as many cycles as its lead.
- R5: The phase error of a comparison is the number of cycles in which exactly one of `up` and `dn` was high since the previous comparison. The comparison counts as in-lock when that error is at most 2^`win_sel` cycles (1, 2, 4 or 8). Any comparison above the window clears the run of in-lock comparisons.
- R6: `locked` rises in the cycle after the Nth consecutive in-lock comparison, where N = 2^(`cnt_sel`+1) (2, 4, 8 or 16). A comparison means one cycle with `up` and `dn` both high.
- R7: A one-cycle `div_wr` clears `locked` on the next cycle and restarts the count. With `lock_en` = 1, it drives `hi_cur` high two cycles after the strobe.
- R8: With `lock_en` = 1, `hi_cur` is the inverse of `locked`, one cycle later. With `lock_en` = 0, `hi_cur` follows `sw_hi` with one cycle of delay.
- R9: While `rst` is high, `up`, `dn` and `locked` are 0 and `hi_cur` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle event per oscillator period |
| vco_tick | input | 1 | One-cycle event per VCO period |
| ref_div | input | 12 | Reference division minus one |
| swal_cnt | input | 5 | Number of divide-by-33 prescaler periods |
| main_cnt | input | 11 | Main counter value |
| win_sel | input | 2 | Phase-error window select |
| cnt_sel | input | 2 | Required in-lock comparison count select |
| lock_en | input | 1 | Automatic current selection enable |
| sw_hi | input | 1 | Software high-current request when automatic selection is off |
| div_wr | input | 1 | Divider reprogramming strobe |
| up | output | 1 | Pump-up pulse |
| dn | output | 1 | Pump-down pulse |
| hi_cur | output | 1 | High charge-pump current select |
| locked | output | 1 | Lock indication |

## Verification
The hardest condition to reach from the ports is a steady phase offset of an exact number of cycles, held long enough for the qualifier to decide. The stimulus makes this offset by holding reset on both dividers and then starting one event stream a chosen number of cycles after the other, with equal division. This gives an error of exactly that many cycles in every comparison. The window can then be probed just inside and just outside its limit, and the comparisons can be counted up to the rise of `locked`.

// File: rtl/pll_pkg.sv
package pll_pkg;
  localparam int PRE_MOD = 32;

  function automatic int unsigned win_cycles(input logic [1:0] sel);
    return 32'd1 << sel;
  endfunction

  function automatic int unsigned need_count(input logic [1:0] sel);
    return 32'd2 << sel;
  endfunction
endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [RW-1:0] r_val,
  output logic          ref_pulse
);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= 1'b0;
      if (tick) begin
        if (cnt >= r_val) begin
          cnt       <= '0;
          ref_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (rst)
    (ref_pulse && r_val != '0) |=> (!ref_pulse || r_val == '0));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int AW  = 5,
  parameter int BW  = 11,
  parameter int PRE = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [AW-1:0] a_val,
  input  logic [BW-1:0] b_val,
  output logic          fb_pulse
);
  localparam int PW = $clog2(PRE + 1);

  logic [PW-1:0] pc;
  logic [BW-1:0] sc;
  logic [PW-1:0] pc_last;
  logic          swallow;

  // modulus 33 while the swallow count is not used up, 32 afterwards
  assign swallow = (sc < BW'(a_val));
  assign pc_last = swallow ? PW'(PRE) : PW'(PRE - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      sc       <= '0;
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= 1'b0;
      if (tick) begin
        if (pc >= pc_last) begin
          pc <= '0;
          if (sc >= b_val) begin
            sc       <= '0;
            fb_pulse <= 1'b1;
          end else begin
            sc <= sc + 1'b1;
          end
        end else begin
          pc <= pc + 1'b1;
        end
      end
    end
  end

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);
endmodule

// File: rtl/phase_detector.sv
module phase_detector (
  input  logic clk,
  input  logic rst,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic up,
  output logic dn
);
  logic both;
  assign both = up & dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (both) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up | ref_pulse;
      dn <= dn | fb_pulse;
    end
  end

  a_r4_clear_after_both: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> (!up && !dn));
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import pll_pkg::*;
#(
  parameter int EW = 4,
  parameter int LW = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       up,
  input  logic       dn,
  input  logic [1:0] win_sel,
  input  logic [1:0] cnt_sel,
  input  logic       div_wr,
  input  logic       lock_en,
  input  logic       sw_hi,
  output logic       locked,
  output logic       hi_cur
);
  localparam logic [EW-1:0] ERR_MAX = {EW{1'b1}};

  logic [EW-1:0] err;
  logic [LW-1:0] run;
  logic [LW-1:0] need;
  logic [EW-1:0] win;
  logic          in_win;

  assign need   = LW'(need_count(cnt_sel));
  assign win    = EW'(win_cycles(win_sel));
  assign in_win = (err <= win);

  always_ff @(posedge clk) begin
    if (rst || div_wr) begin
      err    <= '0;
      run    <= '0;
      locked <= 1'b0;
    end else if (up && dn) begin
      err <= '0;
      if (in_win) begin
        run    <= (run >= need) ? need : run + 1'b1;
        locked <= ((run + 1'b1) >= need);
      end else begin
        run    <= '0;
        locked <= 1'b0;
      end
    end else if (up ^ dn) begin
      if (err != ERR_MAX) err <= err + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hi_cur <= 1'b1;
    else     hi_cur <= lock_en ? !locked : sw_hi;
  end

  a_r6_rise_on_compare: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(up && dn));
  a_r7_write_drops_lock: assert property (@(posedge clk) disable iff (rst)
    div_wr |=> !locked);
  a_r8_software_select: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> (hi_cur == $past(sw_hi)));
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core #(
  parameter int RW = 12,
  parameter int AW = 5,
  parameter int BW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_tick,
  input  logic          vco_tick,
  input  logic [RW-1:0] ref_div,
  input  logic [AW-1:0] swal_cnt,
  input  logic [BW-1:0] main_cnt,
  input  logic [1:0]    win_sel,
  input  logic [1:0]    cnt_sel,
  input  logic          lock_en,
  input  logic          sw_hi,
  input  logic          div_wr,
  output logic          up,
  output logic          dn,
  output logic          hi_cur,
  output logic          locked
);
  localparam int EW = 4;
  localparam int LW = 5;

  logic ref_pulse;
  logic fb_pulse;

  ref_divider #(.RW(RW)) u_ref (
    .clk(clk), .rst(rst), .tick(osc_tick), .r_val(ref_div), .ref_pulse(ref_pulse)
  );

  swallow_divider #(.AW(AW), .BW(BW), .PRE(pll_pkg::PRE_MOD)) u_fb (
    .clk(clk), .rst(rst), .tick(vco_tick), .a_val(swal_cnt), .b_val(main_cnt),
    .fb_pulse(fb_pulse)
  );

  phase_detector u_pfd (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .up(up), .dn(dn)
  );

  lock_qualifier #(.EW(EW), .LW(LW)) u_lock (
    .clk(clk), .rst(rst), .up(up), .dn(dn), .win_sel(win_sel), .cnt_sel(cnt_sel),
    .div_wr(div_wr), .lock_en(lock_en), .sw_hi(sw_hi), .locked(locked), .hi_cur(hi_cur)
  );

  a_r9_reset_outputs: assert property (@(posedge clk)
    rst |=> (!up && !dn && !locked && hi_cur));
endmodule

// File: tb/pll_synth_core_test.sv
module pll_synth_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_run = 1'b0, vco_run = 1'b0;
  logic [11:0] ref_div = '0;
  logic [4:0]  swal_cnt = '0;
  logic [10:0] main_cnt = '0;
  logic [1:0]  win_sel = '0, cnt_sel = '0;
  logic        lock_en = 1'b1, sw_hi = 1'b0, div_wr = 1'b0;
  logic        up, dn, hi_cur, locked;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  pll_synth_core uut (
    .clk(clk), .rst(rst), .osc_tick(osc_run), .vco_tick(vco_run),
    .ref_div(ref_div), .swal_cnt(swal_cnt), .main_cnt(main_cnt),
    .win_sel(win_sel), .cnt_sel(cnt_sel), .lock_en(lock_en), .sw_hi(sw_hi),
    .div_wr(div_wr), .up(up), .dn(dn), .hi_cur(hi_cur), .locked(locked)
  );

  // {swal_cnt, main_cnt, expected division}
  localparam logic [31:0] VEC [6] = '{
    {5'd0,  11'd0,  16'd32},
    {5'd0,  11'd1,  16'd64},
    {5'd1,  11'd1,  16'd65},
    {5'd5,  11'd9,  16'd325},
    {5'd31, 11'd31, 16'd1055},
    {5'd3,  11'd40, 16'd1315}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reset, then start one event stream k cycles after the other
  task automatic start_run(input int k, input bit vco_first);
    @(negedge clk);
    rst = 1'b1; osc_run = 1'b0; vco_run = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    if (vco_first) vco_run = 1'b1; else osc_run = 1'b1;
    repeat (k) @(negedge clk);
    osc_run = 1'b1; vco_run = 1'b1;
  endtask

  // interval between the 2nd and 3rd rise of the selected output
  task automatic rise_period(input bit use_up, output int p);
    int cyc = 0, rises = 0, t2 = 0;
    bit prev = 1'b0, cur;
    p = -1;
    while (cyc < 20000) begin
      @(negedge clk);
      cyc++;
      cur = use_up ? up : dn;
      if (cur && !prev) begin
        rises++;
        if (rises == 2) t2 = cyc;
        if (rises == 3) begin p = cyc - t2; break; end
      end
      prev = cur;
    end
  endtask

  task automatic wait_lock(input int limit, output bit got, output int cmps);
    got = 1'b0; cmps = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (locked) begin got = 1'b1; break; end
      if (up && dn) cmps++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p, cmps, uo, dno;
    bit got;

    // R9 reset state
    repeat (3) @(negedge clk);
    check(!up && !dn, "R9 pump outputs idle", {up, dn}, 0);
    check(hi_cur && !locked, "R9 high current unlocked", {hi_cur, locked}, 2);

    // R2 / R3 division table, reference strobing every cycle
    ref_div = 12'd0; lock_en = 1'b0;
    for (int v = 0; v < 6; v++) begin
      swal_cnt = VEC[v][31:27];
      main_cnt = VEC[v][26:16];
      start_run(0, 1'b0);
      rise_period(1'b0, p);
      check(p == int'(VEC[v][15:0]), (v == 0 || v == 4) ? "R3 boundary division" : "R2 division",
            p, int'(VEC[v][15:0]));
    end

    // R1 reference division with faster feedback
    swal_cnt = 5'd0; main_cnt = 11'd0;
    ref_div = 12'd99; start_run(0, 1'b0); rise_period(1'b1, p);
    check(p == 100, "R1 reference division 100", p, 100);
    ref_div = 12'd40; start_run(0, 1'b0); rise_period(1'b1, p);
    check(p == 41, "R1 reference division 41", p, 41);

    // R4 polarity: equal division 64, offsets
    ref_div = 12'd63; swal_cnt = 5'd0; main_cnt = 11'd1;
    start_run(3, 1'b0);
    uo = 0; dno = 0;
    repeat (400) begin
      @(negedge clk);
      if (up && !dn) uo++;
      if (dn && !up) dno++;
    end
    check(uo > 0 && dno == 0, "R4 reference leads gives up only", uo * 1000 + dno, 1);
    start_run(3, 1'b1);
    uo = 0; dno = 0;
    repeat (400) begin
      @(negedge clk);
      if (up && !dn) uo++;
      if (dn && !up) dno++;
    end
    check(dno > 0 && uo == 0, "R4 feedback leads gives dn only", dno * 1000 + uo, 1);

    // R5 window edges
    lock_en = 1'b1; cnt_sel = 2'd0;
    win_sel = 2'd0; start_run(3, 1'b0); wait_lock(1500, got, cmps);
    check(!got, "R5 error 3 outside window 1", got, 0);
    win_sel = 2'd2; start_run(3, 1'b0); wait_lock(1500, got, cmps);
    check(got, "R5 error 3 inside window 4", got, 1);
    win_sel = 2'd2; start_run(4, 1'b0); wait_lock(1500, got, cmps);
    check(got, "R5 error 4 at window 4", got, 1);
    win_sel = 2'd2; start_run(5, 1'b1); wait_lock(1500, got, cmps);
    check(!got, "R5 error 5 outside window 4", got, 0);

    // R6 number of comparisons before lock
    win_sel = 2'd0;
    for (int s = 0; s < 4; s++) begin
      cnt_sel = 2'(s);
      start_run(0, 1'b0); wait_lock(3000, got, cmps);
      check(got && cmps == (2 << s), "R6 comparisons before lock", cmps, 2 << s);
    end

    // R8 current follows lock
    @(negedge clk);
    check(locked && !hi_cur, "R8 locked gives low current", hi_cur, 0);

    // R7 reprogramming strobe
    div_wr = 1'b1; @(negedge clk); div_wr = 1'b0;
    check(!locked, "R7 lock cleared after write", locked, 0);
    @(negedge clk);
    check(hi_cur, "R7 high current after write", hi_cur, 1);

    // R8 software select
    lock_en = 1'b0; sw_hi = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!hi_cur, "R8 software low current", hi_cur, 0);
    sw_hi = 1'b1; @(negedge clk);
    check(hi_cur, "R8 software high current", hi_cur, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule